// File: doc/BRIEF.md
# SDRAM Bank State and Timing Tracker

This block sits next to the command issuer of an SDRAM controller and watches every command the issuer puts on the chip-select, row-strobe, column-strobe and write-enable lines. It also watches the bank-select bits and the address bus. Address bit 10 is the auto-precharge / all-banks flag. For each of four banks it tracks the state (idle, opening, open or closing), the row that is open, and a set of down-counters for the minimum spacing rules. These are activate-to-column, activate-to-precharge, precharge-to-activate, activate-to-activate on the same bank, activate-to-activate across banks, and write recovery. All of them are counted in clock cycles.

The issuer presents a candidate command and reads the combinational `cmd_legal` flag in the same cycle. A legal command updates the bank model at the next rising edge. An illegal one leaves the model untouched and raises `viol` for one cycle together with a reason code. Reads and writes with the auto-precharge flag set close their bank by themselves once the burst and the recovery time have passed. During that wait the bank refuses column commands, while the other banks keep working. The burst length is a parameter, because the mode register contents are outside this block.

Top module: `sdram_bank_tracker`

## Requirements
- R1: With `cs_n` low, the strobes {`ras_n`,`cas_n`,`we_n`} decode as 011 activate, 101 read, 100 write, 010 precharge and 001 refresh. With `cs_n` high (deselect), and for 111, 000 and 110, the command is always legal and changes no state.
- R2: After a synchronous active-low reset, every bank is idle (`bank_state` = 0) and `viol` is low.
- R3: Bank i is reported in `bank_state[2i+1:2i]` as 0 idle, 1 opening, 2 open, 3 closing. An accepted activate shows 1 from the next cycle, and 2 once tRCD cycles have passed. An accepted precharge shows 3, then 0 once tRP cycles have passed. `sel_row` gives the row held by the bank that `ba` selects.
- R4: A read or write is legal on an opening or open bank only when it comes at least tRCD (3) cycles after that bank's activate (code 2). A read or write to an idle or closing bank gives code 1.
- R5: A precharge of an open bank is legal only when it comes at least tRAS (6) cycles after that bank's activate (code 3).
- R6: A precharge of a written bank is legal only when it comes at least BL-1+tWR (5) cycles after its last write command. The tRAS rule is checked first (code 4).
- R7: An activate to an opening or open bank gives code 1. It must come at least tRP (3) cycles after the bank's precharge (code 5), and at least tRC (9) cycles after the bank's previous activate (code 7).
- R8: Two accepted activates must be at least tRRD (2) cycles apart (code 6).
- R9: After a read with bit 10 set, the next activate to that bank is legal after BL+tRP (7) cycles. After a write with bit 10 set, the wait is BL+tWR-1+tRP (8) cycles. An early activate gives code 5.
- R10: While an auto-precharge is pending, a read or write to that bank gives code 1. A read or write to another open bank stays legal.
- R11: A precharge with bit 10 high is checked against every opening or open bank and closes all of them. When it is illegal, the code is that of the lowest-numbered failing bank.
- R12: A refresh is legal only when every bank is idle (code 1).
- R13: `cmd_legal` is combinational in the command's own cycle. After an illegal command, `viol` is high in the next cycle for exactly one cycle with `viol_code`, and neither bank states nor open rows change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select of the watched command, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Row address; bit 10 is the auto-precharge / all-banks flag |
| ba | input | 2 | Bank select |
| cmd_legal | output | 1 | Candidate command meets every rule (same cycle) |
| viol | output | 1 | One-cycle pulse after an illegal command |
| viol_code | output | 3 | Reason: 0 none, 1 state, 2 tRCD, 3 tRAS, 4 write recovery, 5 tRP, 6 tRRD, 7 tRC |
| bank_state | output | 8 | Two bits per bank, bank 0 in bits 1:0 |
| sel_row | output | 13 | Open row of the bank selected by `ba` |

## Verification
`cmd_legal` settles in the same cycle that the command is driven, so the bench drives at the falling edge and samples it two nanoseconds later, before the capturing rising edge. `viol`, `viol_code`, `bank_state` and `sel_row` change one register stage after that edge, so the bench reads them just after the edge that captured the command. Each sweep holds an interval distance d and expects the command at cycle d to be legal exactly when d reaches the limit worked out in the bench from the timing parameters. Each sweep point starts from a fresh reset, so one point never disturbs the next.

// File: rtl/sdram_trk_pkg.sv
// Shared types for the SDRAM bank tracker.
// Assumes four-state bank tracking and a 3-bit violation code.
package sdram_trk_pkg;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPENING = 2'd1,
        BK_OPEN    = 2'd2,
        BK_CLOSING = 2'd3
    } bank_st_e;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_OTHER
    } cmd_e;

    typedef enum logic [2:0] {
        VC_NONE  = 3'd0,
        VC_STATE = 3'd1,
        VC_RCD   = 3'd2,
        VC_RAS   = 3'd3,
        VC_WREC  = 3'd4,
        VC_RP    = 3'd5,
        VC_RRD   = 3'd6,
        VC_RC    = 3'd7
    } vcode_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Decodes the strobe lines of one command slot into a command kind.
// Assumes active-low strobes; deselect and unused codes become NOP/OTHER.
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e kind
);

    // Map the strobe pattern to a command kind.
    always_comb begin
        if (cs_n) begin
            kind = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  kind = CMD_ACT;
                3'b101:  kind = CMD_RD;
                3'b100:  kind = CMD_WR;
                3'b010:  kind = CMD_PRE;
                3'b001:  kind = CMD_REF;
                3'b111:  kind = CMD_NOP;
                default: kind = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_ctx.sv
// State, open row and interval counters of one SDRAM bank.
// Assumes the caller asserts a *_go strobe only for commands it judged legal.
// A counter loaded with N-1 reaches zero in the N-th cycle after the load.
module sdram_bank_ctx
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_WR  = 2,
    parameter int T_RC  = 9,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             col_go,
    input  logic             col_wr,
    input  logic             col_ap,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    output bank_st_e         st,
    output logic [ROW_W-1:0] row_q,
    output logic             is_open,
    output logic             act_ready,
    output logic             col_ready,
    output logic             ras_done,
    output logic             wr_done,
    output logic             rc_done
);

    localparam int CW = $clog2(BURST + T_WR + T_RP + T_RC + T_RAS + T_RCD + 2);
    localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_WR  = CW'(BURST + T_WR - 2);
    localparam logic [CW-1:0] LD_RAP = CW'(BURST + T_RP - 1);
    localparam logic [CW-1:0] LD_WAP = CW'(BURST + T_WR + T_RP - 2);

    logic [CW-1:0] rcd_c, ras_c, rc_c, rp_c, wr_c;

    // Advance the bank state and reload or count down the interval counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= BK_IDLE;
            row_q <= '0;
            rcd_c <= '0;
            ras_c <= '0;
            rc_c  <= '0;
            rp_c  <= '0;
            wr_c  <= '0;
        end else begin
            rcd_c <= (rcd_c != '0) ? rcd_c - 1'b1 : rcd_c;
            ras_c <= (ras_c != '0) ? ras_c - 1'b1 : ras_c;
            rc_c  <= (rc_c  != '0) ? rc_c  - 1'b1 : rc_c;
            rp_c  <= (rp_c  != '0) ? rp_c  - 1'b1 : rp_c;
            wr_c  <= (wr_c  != '0) ? wr_c  - 1'b1 : wr_c;
            if (act_go) begin
                st    <= BK_OPENING;
                row_q <= row_in;
                rcd_c <= LD_RCD;
                ras_c <= LD_RAS;
                rc_c  <= LD_RC;
            end else if (col_go && col_ap) begin
                st   <= BK_CLOSING;
                rp_c <= col_wr ? LD_WAP : LD_RAP;
            end else if (pre_go && is_open) begin
                st   <= BK_CLOSING;
                rp_c <= LD_RP;
            end else if (st == BK_OPENING && rcd_c == '0) begin
                st <= BK_OPEN;
            end else if (st == BK_CLOSING && rp_c == '0) begin
                st <= BK_IDLE;
            end
            if (col_go && col_wr) begin
                wr_c <= LD_WR;
            end
        end
    end

    // Readiness flags the tracker uses to judge the next command.
    always_comb begin
        is_open   = (st == BK_OPENING) || (st == BK_OPEN);
        act_ready = (st == BK_IDLE) || (st == BK_CLOSING && rp_c == '0);
        col_ready = (st == BK_OPEN) || (st == BK_OPENING && rcd_c == '0);
        ras_done  = (ras_c == '0);
        wr_done   = (wr_c == '0);
        rc_done   = (rc_c == '0);
    end

    AST_OPEN_FROM_OPENING: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_OPEN && $past(st) != BK_OPEN) |-> $past(st) == BK_OPENING); // R3
    AST_IDLE_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_IDLE && $past(st) == BK_CLOSING) |-> $past(rp_c) == '0); // R7
    AST_COL_ON_READY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        col_go |-> (st == BK_OPEN || (st == BK_OPENING && rcd_c == '0))); // R4
    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_go && is_open) |-> (ras_c == '0 && wr_c == '0)); // R5

endmodule

// File: rtl/sdram_bank_tracker.sv
// Watches an SDRAM command stream and judges each command against the
// per-bank state and the cycle-counted spacing rules.
// Assumes the burst length is fixed by parameter and one command per cycle.
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10,
    parameter int T_RCD  = 3,
    parameter int T_RAS  = 6,
    parameter int T_RP   = 3,
    parameter int T_RRD  = 2,
    parameter int T_WR   = 2,
    parameter int T_RC   = 9,
    parameter int BURST  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [ROW_W-1:0]          addr,
    input  logic [BANK_W-1:0]         ba,
    output logic                      cmd_legal,
    output logic                      viol,
    output logic [2:0]                viol_code,
    output logic [2*(1<<BANK_W)-1:0]  bank_state,
    output logic [ROW_W-1:0]          sel_row
);

    localparam int NB  = 1 << BANK_W;
    localparam int RW  = $clog2(T_RRD + 2);
    localparam logic [RW-1:0] LD_RRD  = RW'(T_RRD - 1);
    localparam logic [RW-1:0] GAP_SAT = RW'(T_RRD);

    cmd_e              kind;
    vcode_e            code;
    logic              a10;
    logic [RW-1:0]     rrd_c;
    logic [RW-1:0]     act_gap;
    logic [NB-1:0]     act_go_v, col_go_v, pre_go_v;
    logic [NB-1:0]     open_v, idle_v, act_rdy_v, col_rdy_v, ras_ok_v, wr_ok_v, rc_ok_v;
    logic [ROW_W-1:0]  row_a [NB];
    logic [NB*ROW_W-1:0] row_flat;

    assign a10 = addr[AP_BIT];

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .kind  (kind)
    );

    // Judge the candidate command and pick the reason code.
    always_comb begin
        code = VC_NONE;
        unique case (kind)
            CMD_ACT: begin
                if (open_v[ba])            code = VC_STATE;
                else if (!act_rdy_v[ba])   code = VC_RP;
                else if (!rc_ok_v[ba])     code = VC_RC;
                else if (rrd_c != '0)      code = VC_RRD;
            end
            CMD_RD, CMD_WR: begin
                if (!col_rdy_v[ba])        code = open_v[ba] ? VC_RCD : VC_STATE;
            end
            CMD_PRE: begin
                for (int i = 0; i < NB; i++) begin
                    if (code == VC_NONE && (a10 || ba == BANK_W'(i)) && open_v[i]) begin
                        if (!ras_ok_v[i])      code = VC_RAS;
                        else if (!wr_ok_v[i])  code = VC_WREC;
                    end
                end
            end
            CMD_REF: begin
                if (!(&idle_v))            code = VC_STATE;
            end
            default: ;
        endcase
        cmd_legal = (code == VC_NONE);
    end

    // Steer accepted commands to the banks they affect.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            act_go_v[i] = cmd_legal && kind == CMD_ACT && ba == BANK_W'(i);
            col_go_v[i] = cmd_legal && (kind == CMD_RD || kind == CMD_WR) && ba == BANK_W'(i);
            pre_go_v[i] = cmd_legal && kind == CMD_PRE && (a10 || ba == BANK_W'(i));
        end
    end

    // Cross-bank activate spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             rrd_c <= '0;
        else if (|act_go_v)     rrd_c <= LD_RRD;
        else if (rrd_c != '0)   rrd_c <= rrd_c - 1'b1;
    end

    // Register the violation pulse and its reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= 3'd0;
        end else begin
            viol      <= !cmd_legal;
            viol_code <= code;
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_bank
        bank_st_e st_g;
        sdram_bank_ctx #(
            .ROW_W (ROW_W), .T_RCD (T_RCD), .T_RAS (T_RAS), .T_RP (T_RP),
            .T_WR  (T_WR),  .T_RC  (T_RC),  .BURST (BURST)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_go_v[g]),
            .col_go    (col_go_v[g]),
            .col_wr    (kind == CMD_WR),
            .col_ap    (a10),
            .pre_go    (pre_go_v[g]),
            .row_in    (addr),
            .st        (st_g),
            .row_q     (row_a[g]),
            .is_open   (open_v[g]),
            .act_ready (act_rdy_v[g]),
            .col_ready (col_rdy_v[g]),
            .ras_done  (ras_ok_v[g]),
            .wr_done   (wr_ok_v[g]),
            .rc_done   (rc_ok_v[g])
        );
        assign idle_v[g]               = (st_g == BK_IDLE);
        assign bank_state[2*g +: 2]    = st_g;
        assign row_flat[g*ROW_W +: ROW_W] = row_a[g];
    end

    assign sel_row = row_a[ba];

    // Checker: cycles since the last accepted activate, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 act_gap <= GAP_SAT;
        else if (|act_go_v)         act_gap <= RW'(1);
        else if (act_gap < GAP_SAT) act_gap <= act_gap + 1'b1;
    end

    AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_go_v) |-> act_gap >= GAP_SAT); // R8
    AST_ILLEGAL_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $stable(row_flat)); // R13
    AST_SINGLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_go_v)); // R7
    AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_REF && cmd_legal) |-> bank_state == '0); // R12

endmodule

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;

    localparam int TRCD = 3, TRAS = 6, TRP = 3, TRRD = 2, TWR = 2, TRC = 9, BL = 4;
    localparam logic [3:0] K_ACT = 4'b0011, K_RD = 4'b0101, K_WR = 4'b0100,
                           K_PRE = 4'b0010, K_REF = 4'b0001, K_NOP = 4'b0111,
                           K_MRS = 4'b0000, K_DES = 4'b1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic        cmd_legal, viol;
    logic [2:0]  viol_code;
    logic [7:0]  bank_state;
    logic [12:0] sel_row;

    int checks = 0, errors = 0;
    logic lg, vq;
    logic [2:0] vc;

    always #10 clk = ~clk;

    sdram_bank_tracker u0 (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .addr (addr), .ba (ba), .cmd_legal (cmd_legal), .viol (viol),
        .viol_code (viol_code), .bank_state (bank_state), .sel_row (sel_row)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] k, input logic [1:0] b, input logic ap, input logic [12:0] r);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = k;
        ba = b;
        addr = r;
        addr[10] = ap;
        #2 lg = cmd_legal;
        @(posedge clk);
        #2 vq = viol;
        vc = viol_code;
    endtask

    task automatic nops(input int n);
        for (int j = 0; j < n; j++) step(K_NOP, 2'd0, 1'b0, 13'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = K_NOP;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic outcome(input string tag, input bit exp_legal, input int exp_code);
        chk({tag, " legal"}, int'(lg), int'(exp_legal));
        chk({tag, " viol"}, int'(vq), int'(!exp_legal));
        chk({tag, " code"}, int'(vc), exp_legal ? 0 : exp_code);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        checks++;
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        chk("R2 reset bank_state", int'(bank_state), 0);
        chk("R2 reset viol", int'(viol), 0);

        // R1: deselect and unused codes are always legal
        step(K_DES, 2'd1, 1'b1, 13'h1FFF);
        outcome("R1 deselect", 1'b1, 0);
        step(K_MRS, 2'd0, 1'b0, 13'h0030);
        outcome("R1 mode set", 1'b1, 0);
        chk("R1 no state change", int'(bank_state), 0);

        // R3, R13: activate, open row, illegal re-activate keeps the row
        do_reset();
        step(K_ACT, 2'd0, 1'b0, 13'h123);
        outcome("R3 act", 1'b1, 0);
        chk("R3 opening state", int'(bank_state), 8'h01);
        chk("R3 sel_row", int'(sel_row), 13'h123);
        nops(3);
        chk("R3 open state", int'(bank_state), 8'h02);
        step(K_ACT, 2'd0, 1'b0, 13'h0AA);
        outcome("R7 act on open bank", 1'b0, 1);
        chk("R13 row kept", int'(sel_row), 13'h123);
        chk("R13 state kept", int'(bank_state), 8'h02);
        step(K_NOP, 2'd0, 1'b0, 13'd0);
        chk("R13 viol one cycle", int'(vq), 0);

        // R4: activate-to-column sweep
        for (int d = 1; d <= 5; d++) begin
            do_reset();
            step(K_ACT, 2'd2, 1'b0, 13'h010);
            nops(d - 1);
            step(K_RD, 2'd2, 1'b0, 13'h004);
            outcome($sformatf("R4 trcd d=%0d", d), d >= TRCD, 2);
        end
        do_reset();
        step(K_WR, 2'd3, 1'b0, 13'h0);
        outcome("R4 column to idle bank", 1'b0, 1);

        // R5: activate-to-precharge sweep
        for (int d = 1; d <= 8; d++) begin
            do_reset();
            step(K_ACT, 2'd1, 1'b0, 13'h020);
            nops(d - 1);
            step(K_PRE, 2'd1, 1'b0, 13'h0);
            outcome($sformatf("R5 tras d=%0d", d), d >= TRAS, 3);
        end

        // R6: write recovery sweep (write at cycle 3, precharge at 3+k)
        for (int k = 1; k <= 7; k++) begin
            do_reset();
            step(K_ACT, 2'd0, 1'b0, 13'h040);
            nops(2);
            step(K_WR, 2'd0, 1'b0, 13'h0);
            nops(k - 1);
            step(K_PRE, 2'd0, 1'b0, 13'h0);
            outcome($sformatf("R6 twr k=%0d", k), (3 + k >= TRAS) && (k >= BL - 1 + TWR),
                    (3 + k < TRAS) ? 3 : 4);
        end

        // R7: precharge-to-activate and row cycle sweep
        for (int p = 6; p <= 7; p++) begin
            for (int q = 1; q <= 4; q++) begin
                do_reset();
                step(K_ACT, 2'd0, 1'b0, 13'h050);
                nops(p - 1);
                step(K_PRE, 2'd0, 1'b0, 13'h0);
                nops(q - 1);
                step(K_ACT, 2'd0, 1'b0, 13'h051);
                outcome($sformatf("R7 trp p=%0d q=%0d", p, q), (q >= TRP) && (p + q >= TRC),
                        (q < TRP) ? 5 : 7);
            end
        end

        // R8: cross-bank activate spacing
        for (int d = 1; d <= 3; d++) begin
            do_reset();
            step(K_ACT, 2'd0, 1'b0, 13'h060);
            nops(d - 1);
            step(K_ACT, 2'd1, 1'b0, 13'h061);
            outcome($sformatf("R8 trrd d=%0d", d), d >= TRRD, 6);
        end

        // R9: read with auto-precharge (read at 3, activate at 3+q)
        for (int q = 1; q <= 8; q++) begin
            do_reset();
            step(K_ACT, 2'd0, 1'b0, 13'h070);
            nops(2);
            step(K_RD, 2'd0, 1'b1, 13'h0);
            nops(q - 1);
            step(K_ACT, 2'd0, 1'b0, 13'h071);
            outcome($sformatf("R9 reada q=%0d", q), q >= BL + TRP, 5);
        end
        // R9: write with auto-precharge
        for (int q = 6; q <= 9; q++) begin
            do_reset();
            step(K_ACT, 2'd0, 1'b0, 13'h080);
            nops(2);
            step(K_WR, 2'd0, 1'b1, 13'h0);
            nops(q - 1);
            step(K_ACT, 2'd0, 1'b0, 13'h081);
            outcome($sformatf("R9 writea q=%0d", q), q >= BL + TWR - 1 + TRP, 5);
        end

        // R10: pending auto-precharge blocks same bank, not another bank
        do_reset();
        step(K_ACT, 2'd0, 1'b0, 13'h090);
        nops(1);
        step(K_ACT, 2'd1, 1'b0, 13'h091);
        step(K_RD, 2'd0, 1'b1, 13'h0);
        outcome("R10 reada accepted", 1'b1, 0);
        step(K_WR, 2'd0, 1'b0, 13'h0);
        outcome("R10 same bank blocked", 1'b0, 1);
        step(K_RD, 2'd1, 1'b0, 13'h0);
        outcome("R10 other bank read", 1'b1, 0);

        // R11, R12: all-bank precharge and refresh
        do_reset();
        step(K_ACT, 2'd0, 1'b0, 13'h0A0);
        nops(1);
        step(K_ACT, 2'd1, 1'b0, 13'h0A1);
        nops(3);
        step(K_PRE, 2'd2, 1'b1, 13'h0);
        outcome("R11 all-bank early", 1'b0, 3);
        chk("R11 states kept", int'(bank_state), 8'h0A);
        nops(1);
        step(K_PRE, 2'd2, 1'b1, 13'h0);
        outcome("R11 all-bank ok", 1'b1, 0);
        chk("R11 closing states", int'(bank_state), 8'h0F);
        step(K_REF, 2'd0, 1'b0, 13'h0);
        outcome("R12 refresh busy", 1'b0, 1);
        nops(2);
        step(K_REF, 2'd0, 1'b0, 13'h0);
        outcome("R12 refresh idle", 1'b1, 0);
        chk("R3 idle after trp", int'(bank_state), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule